// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor's load/store port and a four-bank main memory. It is a write-back, write-allocate cache with two ways. Each way is a direct-mapped array of 256 lines, and each line holds four 16-bit words. A request is a single read or write of one 16-bit word at a byte address. The block looks up both ways at once. A hit finishes in the request cycle. A miss holds the processor off with a stall signal while the controller works. If the line being replaced is dirty, the controller first writes it back to memory. It then fetches the new line four words at a time and merges any pending write into it.

When a miss finds both ways of a set valid, the replacement way comes from a single toggling bit. The bit flips on every accepted request, whether it hits or misses. When one way is still invalid, that way is used instead of the toggling bit. The controller is a Moore-style sequencer with four states: idle, write-back, fill and done.

The backing memory has four banks, selected by the low two bits of the word address. A read returns data two cycles after it is issued. Each bank stays busy for four cycles after it accepts a request.

Top module: `tw_cache_sys`

## Requirements
- R1: The byte address splits as tag = addr[15:11], set index = addr[10:3] and word select = addr[2:1]; addr[0] is ignored. Two ways of 256 lines by four 16-bit words each are searched in parallel.
- R2: A request that hits in either way raises done and hit in the request cycle itself, with stall low. A read hit returns the addressed word on rdata in that same cycle.
- R3: A write hit stores the word in the hitting line and marks that line dirty. A later read returns the new word, and a later eviction of that line pays the write-back delay.
- R4: On a miss, stall is high from the request cycle until the cycle before done. In the done cycle, done is high with hit and stall low. A miss whose victim is clean raises done exactly 7 cycles after the request cycle.
- R5: On a miss whose victim line is valid and dirty, the four victim words are first written to memory at the victim tag's address, on consecutive banks. Done then comes exactly 11 cycles after the request cycle, and a later read of any written-back word returns its last written value.
- R6: A write miss allocates the line: the block is fetched and the write is merged into it before done. A later read of the address hits and returns the written value.
- R7: The replacement bit is 0 after reset and is inverted on every accepted read or write request, hits included.
- R8: On a miss where both ways of the set are invalid, the block goes to way 0. Where exactly one way is invalid, the block goes to that way.
- R9: On a miss where both ways of the set are valid, the block replaces the way named by the replacement bit, using its value before that request's inversion.
- R10: When rd and wr are both high, err is high in that cycle. The request is ignored: no done, no stall, no change to the replacement bit, and no change to cache contents.
- R11: During and right after reset, done, stall, hit and err are low, all lines are invalid, and the backing memory starts at all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Byte address of the request |
| cpu_wdata | input | 16 | Write data |
| cpu_rd | input | 1 | Read request, held until done |
| cpu_wr | input | 1 | Write request, held until done |
| cpu_rdata | output | 16 | Read data, valid while done is high on a read |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | High while a miss is being serviced |
| cpu_hit | output | 1 | High with done when the request hit |
| cpu_err | output | 1 | High when rd and wr are both asserted |

## Verification
A wrong replacement bit, or a wrong way choice, stays hidden until a later request to the same set. That request then hits where it should miss, or misses where it should hit, and the hit flag is wrong in its very first cycle. A lost dirty bit or a broken write-back does not show up in latency alone: the first sign is stale data when the evicted address is read again, possibly hundreds of requests later. For that reason the stimulus packs its traffic into a few sets and a few tags. Sequencing faults in the miss path show up as a done pulse that arrives at the wrong cycle count, or as stall dropping before done.

// File: rtl/tw_cache_pkg.sv
`timescale 1ns/1ps
package tw_cache_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int TAG_W   = 5;
  localparam int IDX_W   = 8;
  localparam int OFS_W   = 3;
  localparam int WSEL_W  = OFS_W - 1;
  localparam int LINE_WORDS = 1 << WSEL_W;
  localparam int LINES   = 1 << IDX_W;
  localparam int WAYS    = 2;
  localparam int BLK_WADDR_W = TAG_W + IDX_W + WSEL_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } ctrl_state_t;

  typedef struct packed {
    logic              en;
    logic              comp;
    logic              write;
    logic              valid_in;
    logic [IDX_W-1:0]  index;
    logic [WSEL_W-1:0] word;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] wdata;
  } way_cmd_t;

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] addr_word(input logic [ADDR_W-1:0] a);
    return a[1 +: WSEL_W];
  endfunction

  function automatic logic [BLK_WADDR_W-1:0] blk_word_addr(
      input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] i, input logic [WSEL_W-1:0] w);
    return {t, i, w};
  endfunction

  // invalid way first (way 0 before way 1), else the toggling bit
  function automatic logic pick_way(input logic v0, input logic v1, input logic vic);
    if (!v0)      return 1'b0;
    else if (!v1) return 1'b1;
    else          return vic;
  endfunction
endpackage

// File: rtl/tw_line_array.sv
`timescale 1ns/1ps
module tw_line_array
  import tw_cache_pkg::*;
#(
  parameter int N_LINES = LINES
) (
  input  logic              clk,
  input  logic              rst,
  input  way_cmd_t          cmd_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LI_W = $clog2(N_LINES);

  logic [N_LINES-1:0] valid_q;
  logic [N_LINES-1:0] dirty_q;
  logic [TAG_W-1:0]   tag_q  [N_LINES];
  logic [DATA_W-1:0]  data_q [N_LINES][LINE_WORDS];

  logic [LI_W-1:0] li;
  logic            match;
  logic            wr_cmp_ev;
  logic            wr_acc_ev;

  assign li        = LI_W'(cmd_i.index);
  assign match     = valid_q[li] && (tag_q[li] == cmd_i.tag);
  assign wr_cmp_ev = cmd_i.en && cmd_i.write && cmd_i.comp && match;
  assign wr_acc_ev = cmd_i.en && cmd_i.write && !cmd_i.comp;

  always_comb begin
    valid_o = valid_q[li];
    tag_o   = tag_q[li];
    rdata_o = data_q[li][cmd_i.word];
    hit_o   = cmd_i.en && cmd_i.comp && match;
    dirty_o = dirty_q[li] && !(cmd_i.comp && cmd_i.write && match);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_cmp_ev) begin
      dirty_q[li] <= 1'b1;
    end else if (wr_acc_ev) begin
      valid_q[li] <= cmd_i.valid_in;
      dirty_q[li] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc_ev) tag_q[li] <= cmd_i.tag;
    if (wr_cmp_ev || wr_acc_ev) data_q[li][cmd_i.word] <= cmd_i.wdata;
  end

  // R3
  hit_write_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cmp_ev |=> dirty_q[$past(li)]);
endmodule

// File: rtl/tw_bank_mem.sv
`timescale 1ns/1ps
module tw_bank_mem
  import tw_cache_pkg::*;
#(
  parameter int WADDR_W  = 12,
  parameter int BANKS    = 4,
  parameter int BUSY_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               rd,
  input  logic               wr,
  output logic [DATA_W-1:0]  rdata,
  output logic               rvalid,
  output logic               stall,
  output logic               err
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int CNT_W  = $clog2(BUSY_CYC);
  localparam int DEPTH  = 1 << WADDR_W;

  logic [DATA_W-1:0]  store [DEPTH];
  logic [BANKS-1:0]   bank_busy;
  logic [BANK_W-1:0]  bank_sel;
  logic               accept;
  logic               p1_vld;
  logic [WADDR_W-1:0] p1_addr;

  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = '0;
  end

  assign bank_sel = waddr[BANK_W-1:0];
  assign stall    = (rd || wr) && bank_busy[bank_sel];
  assign accept   = (rd ^ wr) && !bank_busy[bank_sel];
  assign err      = rd && wr;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst)                                 cnt_q <= '0;
      else if (accept && bank_sel == BANK_W'(b)) cnt_q <= CNT_W'(BUSY_CYC - 1);
      else if (cnt_q != '0)                    cnt_q <= cnt_q - 1'b1;
    end
    assign bank_busy[b] = (cnt_q != '0);
  end

  always_ff @(posedge clk) begin
    if (accept && wr) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_vld <= 1'b0;
      rvalid <= 1'b0;
    end else begin
      p1_vld <= accept && rd;
      rvalid <= p1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && rd) p1_addr <= waddr;
    if (p1_vld)       rdata   <= store[p1_addr];
  end

  // R5
  rd_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    p1_vld |=> rvalid);
endmodule

// File: rtl/tw_cache_sys.sv
`timescale 1ns/1ps
module tw_cache_sys
  import tw_cache_pkg::*;
#(
  parameter int MEM_WADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_stall,
  output logic              cpu_hit,
  output logic              cpu_err
);
  localparam int CNT_W = WSEL_W + 1;

  ctrl_state_t       st_q;
  logic              victim_q;
  logic [TAG_W-1:0]  lat_tag, lat_vtag;
  logic [IDX_W-1:0]  lat_idx;
  logic [WSEL_W-1:0] lat_word;
  logic [DATA_W-1:0] lat_wdata;
  logic              lat_wr;
  logic              lat_way;
  logic [WSEL_W-1:0] wb_q;
  logic [CNT_W-1:0]  iss_q;
  logic [WSEL_W-1:0] fill_q;

  logic [WAYS-1:0]   way_hit, way_valid, way_dirty;
  logic [TAG_W-1:0]  way_tag   [WAYS];
  logic [DATA_W-1:0] way_rdata [WAYS];

  logic req, acc, any_hit, miss_ev, hit_ev, pick, addr_unused;
  logic mem_rd, mem_wr, mem_rvalid, mem_stall, mem_err;
  logic [MEM_WADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0]      mem_wdata, mem_rdata;

  assign addr_unused = cpu_addr[0];
  assign req     = cpu_rd ^ cpu_wr;
  assign acc     = (st_q == ST_IDLE) && req;
  assign any_hit = |way_hit;
  assign hit_ev  = acc && any_hit;
  assign miss_ev = acc && !any_hit;
  assign pick    = pick_way(way_valid[0], way_valid[1], victim_q);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    way_cmd_t cmd;
    logic     mine;
    assign mine = (lat_way == 1'(g));
    always_comb begin
      cmd = '0;
      unique case (st_q)
        ST_IDLE: begin
          cmd.en    = req;
          cmd.comp  = 1'b1;
          cmd.write = cpu_wr;
          cmd.index = addr_index(cpu_addr);
          cmd.word  = addr_word(cpu_addr);
          cmd.tag   = addr_tag(cpu_addr);
          cmd.wdata = cpu_wdata;
        end
        ST_WBACK: begin
          cmd.en    = mine;
          cmd.index = lat_idx;
          cmd.word  = wb_q;
        end
        ST_FILL: begin
          cmd.en       = mine;
          cmd.write    = mem_rvalid;
          cmd.valid_in = 1'b1;
          cmd.index    = lat_idx;
          cmd.word     = fill_q;
          cmd.tag      = lat_tag;
          cmd.wdata    = mem_rdata;
        end
        ST_DONE: begin
          cmd.en    = mine;
          cmd.comp  = 1'b1;
          cmd.write = lat_wr;
          cmd.index = lat_idx;
          cmd.word  = lat_word;
          cmd.tag   = lat_tag;
          cmd.wdata = lat_wdata;
        end
        default: cmd = '0;
      endcase
    end

    tw_line_array #(.N_LINES(LINES)) u_way (
      .clk    (clk),
      .rst    (rst),
      .cmd_i  (cmd),
      .hit_o  (way_hit[g]),
      .valid_o(way_valid[g]),
      .dirty_o(way_dirty[g]),
      .tag_o  (way_tag[g]),
      .rdata_o(way_rdata[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      victim_q <= 1'b0;
      wb_q     <= '0;
      iss_q    <= '0;
      fill_q   <= '0;
      lat_way  <= 1'b0;
      lat_wr   <= 1'b0;
    end else begin
      if (acc) victim_q <= ~victim_q;
      unique case (st_q)
        ST_IDLE: if (miss_ev) begin
          lat_way <= pick;
          lat_wr  <= cpu_wr;
          wb_q    <= '0;
          iss_q   <= '0;
          fill_q  <= '0;
          st_q    <= (way_valid[pick] && way_dirty[pick]) ? ST_WBACK : ST_FILL;
        end
        ST_WBACK: if (!mem_stall) begin
          wb_q <= wb_q + 1'b1;
          if (wb_q == WSEL_W'(LINE_WORDS - 1)) st_q <= ST_FILL;
        end
        ST_FILL: begin
          if (mem_rd && !mem_stall) iss_q <= iss_q + 1'b1;
          if (mem_rvalid) begin
            fill_q <= fill_q + 1'b1;
            if (fill_q == WSEL_W'(LINE_WORDS - 1)) st_q <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (miss_ev) begin
      lat_tag   <= addr_tag(cpu_addr);
      lat_idx   <= addr_index(cpu_addr);
      lat_word  <= addr_word(cpu_addr);
      lat_wdata <= cpu_wdata;
      lat_vtag  <= way_tag[pick];
    end
  end

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_waddr = '0;
    mem_wdata = way_rdata[lat_way];
    if (st_q == ST_WBACK) begin
      mem_wr    = 1'b1;
      mem_waddr = MEM_WADDR_W'(blk_word_addr(lat_vtag, lat_idx, wb_q));
    end else if (st_q == ST_FILL) begin
      mem_rd    = (iss_q < CNT_W'(LINE_WORDS));
      mem_waddr = MEM_WADDR_W'(blk_word_addr(lat_tag, lat_idx, iss_q[WSEL_W-1:0]));
    end
  end

  tw_bank_mem #(.WADDR_W(MEM_WADDR_W), .BANKS(LINE_WORDS), .BUSY_CYC(4)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .rd    (mem_rd),
    .wr    (mem_wr),
    .rdata (mem_rdata),
    .rvalid(mem_rvalid),
    .stall (mem_stall),
    .err   (mem_err)
  );

  assign cpu_done  = hit_ev || (st_q == ST_DONE);
  assign cpu_hit   = hit_ev;
  assign cpu_stall = miss_ev || (st_q == ST_WBACK) || (st_q == ST_FILL);
  assign cpu_err   = (cpu_rd && cpu_wr) || mem_err;
  assign cpu_rdata = (st_q == ST_DONE) ? way_rdata[lat_way]
                   : (way_hit[1] ? way_rdata[1] : way_rdata[0]);

  // R1
  way_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));
  // R4
  miss_stall_chk: assert property (@(posedge clk) disable iff (rst)
    miss_ev |=> cpu_stall);
  // R4
  mem_no_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> !mem_stall);
  // R6
  done_line_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE) |-> way_hit[lat_way]);
  // R7
  victim_flip_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> (victim_q != $past(victim_q)));
  // R10
  err_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_wr && st_q == ST_IDLE) |-> (!cpu_done && !cpu_stall));
endmodule

// File: tb/tw_cache_sys_bench.sv
`timescale 1ns/1ps
module tw_cache_sys_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_rdata;
  logic        cpu_done, cpu_stall, cpu_hit, cpu_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tw_cache_sys u_tw_cache_sys (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .cpu_done(cpu_done), .cpu_stall(cpu_stall), .cpu_hit(cpu_hit), .cpu_err(cpu_err)
  );

  // reference model
  bit          mv [2][256];
  bit          md [2][256];
  int          mt [2][256];
  logic [15:0] mem_m [4096];
  bit          victim;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_addr(input int tg, input int ix, input int w);
    return 16'((tg << 11) | (ix << 3) | (w << 1));
  endfunction

  task automatic access(input bit is_wr, input logic [15:0] a, input logic [15:0] d,
                        input string rq);
    int tg, ix, wa, hw, ch, lat, cyc;
    bit exp_hit, timed_out;
    logic [15:0] exp_d;
    tg = int'(a >> 11);
    ix = int'((a >> 3) & 16'hff);
    wa = int'((a >> 1) & 16'hfff);
    hw = -1;
    for (int k = 0; k < 2; k++) if (mv[k][ix] && mt[k][ix] == tg) hw = k;
    exp_hit = (hw >= 0);
    if (exp_hit) begin
      ch = hw; lat = 0;
    end else begin
      ch  = !mv[0][ix] ? 0 : (!mv[1][ix] ? 1 : int'(victim));
      lat = (mv[ch][ix] && md[ch][ix]) ? 11 : 7;
    end
    exp_d = mem_m[wa];

    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = !is_wr; cpu_wr = is_wr;
    #2;
    cyc = 0; timed_out = 1'b0;
    while (!cpu_done) begin
      check(cpu_stall == 1'b1, "R4", "stall while waiting", int'(cpu_stall), 1);
      @(negedge clk); #2;
      cyc++;
      if (cyc > 40) begin timed_out = 1'b1; break; end
    end
    check(!timed_out, "R4", "done arrives", int'(timed_out), 0);
    check(cpu_hit == exp_hit, rq, "hit flag", int'(cpu_hit), int'(exp_hit));
    check(cpu_stall == 1'b0, "R4", "stall low at done", int'(cpu_stall), 0);
    if (exp_hit)
      check(cyc == 0, is_wr ? "R3" : "R2", "hit latency", cyc, 0);
    else
      check(cyc == lat, lat == 11 ? "R5" : "R4", "miss latency", cyc, lat);
    if (!is_wr)
      check(cpu_rdata == exp_d, exp_hit ? "R2" : "R5", "read data",
            int'(cpu_rdata), int'(exp_d));

    if (!exp_hit) begin
      mv[ch][ix] = 1'b1; mt[ch][ix] = tg; md[ch][ix] = 1'b0;
    end
    if (is_wr) begin
      md[ch][ix] = 1'b1;
      mem_m[wa] = d;
    end
    victim = ~victim;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic both_req(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = 16'hdead; cpu_rd = 1'b1; cpu_wr = 1'b1;
    #2;
    check(cpu_err == 1'b1, "R10", "err on rd+wr", int'(cpu_err), 1);
    check(cpu_done == 1'b0, "R10", "no done on rd+wr", int'(cpu_done), 0);
    check(cpu_stall == 1'b0, "R10", "no stall on rd+wr", int'(cpu_stall), 0);
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    #2;
    check(cpu_err == 1'b0, "R10", "err clears", int'(cpu_err), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) mem_m[i] = '0;
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 256; i++) begin mv[k][i] = 0; md[k][i] = 0; mt[k][i] = 0; end
    victim = 1'b0;

    repeat (4) @(negedge clk);
    check({cpu_done, cpu_stall, cpu_hit, cpu_err} == 4'b0, "R11", "outputs in reset",
          int'({cpu_done, cpu_stall, cpu_hit, cpu_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    check({cpu_done, cpu_stall, cpu_hit, cpu_err} == 4'b0, "R11", "outputs after reset",
          int'({cpu_done, cpu_stall, cpu_hit, cpu_err}), 0);

    // replacement walk: invalid-way fill, toggle on hits, victim choice
    access(0, mk_addr(1, 0, 0), 0, "R11");
    access(0, mk_addr(1, 2, 1), 0, "R8");
    access(0, mk_addr(1, 0, 2), 0, "R7");
    access(0, mk_addr(2, 2, 0), 0, "R8");
    access(0, mk_addr(2, 0, 3), 0, "R8");
    access(0, mk_addr(3, 0, 0), 0, "R9");
    access(0, mk_addr(2, 0, 0), 0, "R9");
    access(0, mk_addr(3, 0, 1), 0, "R7");
    access(0, mk_addr(1, 0, 0), 0, "R9");

    // write allocate, write hit, dirty eviction, read back
    access(1, mk_addr(0, 5, 2), 16'h1234, "R6");
    access(0, mk_addr(0, 5, 2), 0, "R6");
    access(1, mk_addr(0, 5, 2), 16'habcd, "R3");
    access(1, mk_addr(1, 5, 0), 16'h0f0f, "R6");
    access(0, mk_addr(2, 5, 0), 0, "R5");
    access(0, mk_addr(3, 5, 0), 0, "R5");
    access(0, mk_addr(0, 5, 2), 0, "R5");
    access(0, mk_addr(1, 5, 0), 0, "R5");

    // conflicting rd+wr is ignored, including by the replacement bit
    both_req(mk_addr(2, 5, 1));
    access(0, mk_addr(2, 5, 1), 0, "R10");
    access(0, mk_addr(3, 7, 0), 0, "R10");
    both_req(mk_addr(3, 7, 0));
    access(0, mk_addr(1, 7, 0), 0, "R10");

    // odd byte address bit ignored
    access(1, mk_addr(0, 9, 3) | 16'h1, 16'h5a5a, "R1");
    access(0, mk_addr(0, 9, 3), 0, "R1");

    for (int n = 0; n < 800; n++) begin
      int tg, ix, w;
      bit wr;
      tg = int'($urandom % 4);
      ix = int'($urandom % 4);
      w  = int'($urandom % 4);
      wr = ($urandom % 2) == 1;
      access(wr, mk_addr(tg, ix, w), 16'($urandom), "R1");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule